// File: doc/BRIEF.md
# Address Mark Sync Detector

This block sits behind a disk read-channel data separator. Every cycle the separator may present one half-bit-cell window: how many pulses fell inside it and whether it is a clock-phase or a data-phase window. While hunting, the block keeps the last 31 window values in a history register. It compares that history against the fixed address-mark patterns of the selected encoding. These marks contain deliberately missing clock pulses, so ordinary data cannot produce them. A match gives byte alignment. The block then reports the mark byte and enters the synchronised state.

Once synchronised, the block assembles bytes MSB first from the data-phase windows only. It checks every bit against the clock rule of the encoding and reports each byte with a one-cycle strobe. The report carries a tag field, a clock-violation flag and an extra-pulse flag. Repeated MFM prefix bytes are recognised and tagged. Clock checking is suppressed on every mark or prefix byte. A downstream record parser pulses `resync` when a record ends or a parse error occurs, which puts the block back into hunting.

Tag encoding on `mark_tag`: 0 = normal data byte, 1 = first MFM prefix, 2 = repeated MFM prefix, 3 = FM address mark.

Top module: `amark_sync`

## Requirements
- R1: While hunting in MFM mode (`fm_mode`=0), a window that makes the 31-window history (newest value in bit 0) equal 0x2AAA4489 causes a byte 0xA1 with tag 1 and no error flags on the next cycle, and `in_sync` rises in the same cycle.
- R2: While hunting in MFM mode, a history of 0x2AAA5224 causes a byte 0xC2 with tag 1 and sets `in_sync`.
- R3: While hunting in FM mode (`fm_mode`=1), the following histories cause the stated byte with tag 3 and set `in_sync`: 0x2AAAF57E gives 0xFE, 0x2AAAF56F gives 0xFB, 0x2AAAF56A gives 0xF8, 0x2AAAF56B gives 0xF9, 0x2AAAF56E gives 0xFA, 0x2AAAF77A gives 0xFC.
- R4: While synchronised, only windows with `win_is_data`=1 enter the byte, first bit in the MSB. The eighth such window produces a `byte_valid` pulse one cycle later, with tag 0 unless R5 applies.
- R5: In MFM mode, if the last 16 window values equal 0x4489 or 0x5224 when a byte completes, that byte is tagged 2.
- R6: In MFM mode, a byte has `clk_err`=1 when, for any of its data windows, the three values (previous data, clock, this data) read 000, 011, 110 or 111.
- R7: In FM mode, a byte has `clk_err`=1 when any of its bits reads 000, 001, 100 or 101 over those three windows, meaning the clock window was empty. A byte of all ones is therefore clean in FM.
- R8: A byte with a nonzero tag always has `clk_err`=0.
- R9: A window with two or more pulses counts as value 1. Any such window within a synchronised byte sets `extra_err` on that byte. On a mark byte, `extra_err` reflects the matching window only.
- R10: While hunting, no `byte_valid` pulse occurs except for a mark match, and `in_sync` stays low.
- R11: A `resync` pulse clears the history, the bit count and `in_sync` in the cycle it is sampled, and takes priority over a window in that cycle. The next byte is reported only after a new mark match.
- R12: After reset, `in_sync` and `byte_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_mode | input | 1 | 1 = FM encoding, 0 = MFM |
| win_valid | input | 1 | A window value is presented this cycle |
| win_pulses | input | PULSE_W | Number of pulses counted in the window (saturated) |
| win_is_data | input | 1 | 1 = data-phase window, 0 = clock-phase window |
| resync | input | 1 | Return to hunting |
| byte_valid | output | 1 | One-cycle byte strobe |
| byte_data | output | 8 | Byte value |
| mark_tag | output | 2 | 0 normal, 1 first prefix, 2 repeated prefix, 3 FM mark |
| clk_err | output | 1 | Clock rule violated within the byte |
| extra_err | output | 1 | A window of the byte held more than one pulse |
| in_sync | output | 1 | Byte alignment established |

## Verification
The embedded checks assume the separator alternates clock and data phases once the block is synchronised. They also assume every mark pattern ends on a data-phase window, and that `fm_mode` changes only together with a `resync` pulse. The stimulus is built from encoder tasks that generate clock and data windows in strict alternation, so a matched mark always closes on a data window. A mode switch is always issued in the same cycle as `resync`. Clock errors and extra pulses are injected by altering a single window inside such an encoded byte, which keeps the phase sequence intact.

// File: rtl/amark_sync.sv
module amark_sync #(
  parameter int PULSE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fm_mode,
  input  logic               win_valid,
  input  logic [PULSE_W-1:0] win_pulses,
  input  logic               win_is_data,
  input  logic               resync,
  output logic               byte_valid,
  output logic [7:0]         byte_data,
  output logic [1:0]         mark_tag,
  output logic               clk_err,
  output logic               extra_err,
  output logic               in_sync
);

  localparam int HIST_W = 31;
  localparam logic [1:0] TAG_NORM = 2'd0;
  localparam logic [1:0] TAG_FIRST = 2'd1;
  localparam logic [1:0] TAG_REPEAT = 2'd2;
  localparam logic [1:0] TAG_FMMARK = 2'd3;

  logic [HIST_W-1:0] hist;
  logic [7:0]        shreg;
  logic [2:0]        bitcnt;
  logic              viol_acc, extra_acc;

  wire              win_bit  = |win_pulses;
  wire              win_xtra = win_pulses > PULSE_W'(1);
  wire [HIST_W-1:0] hist_nx  = {hist[HIST_W-2:0], win_bit};

  logic       hit;
  logic [7:0] hit_byte;
  logic [1:0] hit_tag;

  always_comb begin
    hit = 1'b0;
    hit_byte = 8'h00;
    hit_tag = TAG_NORM;
    if (!fm_mode) begin
      case (hist_nx)
        31'h2AAA4489: begin hit = 1'b1; hit_byte = 8'hA1; hit_tag = TAG_FIRST; end
        31'h2AAA5224: begin hit = 1'b1; hit_byte = 8'hC2; hit_tag = TAG_FIRST; end
        default: ;
      endcase
    end else begin
      case (hist_nx)
        31'h2AAAF57E: begin hit = 1'b1; hit_byte = 8'hFE; hit_tag = TAG_FMMARK; end
        31'h2AAAF56F: begin hit = 1'b1; hit_byte = 8'hFB; hit_tag = TAG_FMMARK; end
        31'h2AAAF56A: begin hit = 1'b1; hit_byte = 8'hF8; hit_tag = TAG_FMMARK; end
        31'h2AAAF56B: begin hit = 1'b1; hit_byte = 8'hF9; hit_tag = TAG_FMMARK; end
        31'h2AAAF56E: begin hit = 1'b1; hit_byte = 8'hFA; hit_tag = TAG_FMMARK; end
        31'h2AAAF77A: begin hit = 1'b1; hit_byte = 8'hFC; hit_tag = TAG_FMMARK; end
        default: ;
      endcase
    end
  end

  logic bit_viol;
  always_comb begin
    if (fm_mode) bit_viol = !hist_nx[1];
    else begin
      case (hist_nx[2:0])
        3'b000, 3'b011, 3'b110, 3'b111: bit_viol = 1'b1;
        default:                        bit_viol = 1'b0;
      endcase
    end
  end

  wire rep_prefix = !fm_mode && (hist_nx[15:0] == 16'h4489 || hist_nx[15:0] == 16'h5224);
  wire viol_now   = viol_acc | (win_is_data & bit_viol);
  wire extra_now  = extra_acc | win_xtra;
  wire byte_done  = win_is_data && bitcnt == 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      shreg <= '0;
      bitcnt <= '0;
      viol_acc <= 1'b0;
      extra_acc <= 1'b0;
      in_sync <= 1'b0;
      byte_valid <= 1'b0;
      byte_data <= '0;
      mark_tag <= TAG_NORM;
      clk_err <= 1'b0;
      extra_err <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (resync) begin
        hist <= '0;
        bitcnt <= '0;
        viol_acc <= 1'b0;
        extra_acc <= 1'b0;
        in_sync <= 1'b0;
      end else if (win_valid) begin
        hist <= hist_nx;
        if (!in_sync) begin
          if (hit) begin
            in_sync <= 1'b1;
            byte_valid <= 1'b1;
            byte_data <= hit_byte;
            mark_tag <= hit_tag;
            clk_err <= 1'b0;
            extra_err <= win_xtra;
            bitcnt <= '0;
            viol_acc <= 1'b0;
            extra_acc <= 1'b0;
          end
        end else begin
          if (win_is_data) begin
            shreg <= {shreg[6:0], win_bit};
            bitcnt <= bitcnt + 3'd1;
          end
          if (byte_done) begin
            byte_valid <= 1'b1;
            byte_data <= {shreg[6:0], win_bit};
            mark_tag <= rep_prefix ? TAG_REPEAT : TAG_NORM;
            clk_err <= rep_prefix ? 1'b0 : viol_now;
            extra_err <= extra_now;
            viol_acc <= 1'b0;
            extra_acc <= 1'b0;
          end else begin
            viol_acc <= viol_now;
            extra_acc <= extra_now;
          end
        end
      end
    end
  end

  // R10
  no_byte_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> in_sync);

  // R8
  mark_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mark_tag != TAG_NORM) |-> !clk_err);

  // R11
  resync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!in_sync && !byte_valid));

  // R1
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> (byte_valid && (mark_tag == TAG_FIRST || mark_tag == TAG_FMMARK)));

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R3
  fm_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && fm_mode) |-> (mark_tag == TAG_NORM || mark_tag == TAG_FMMARK));

endmodule

// File: tb/test_amark_sync.sv
module test_amark_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fm_mode = 1'b0;
  logic       win_valid = 1'b0;
  logic [1:0] win_pulses = 2'd0;
  logic       win_is_data = 1'b0;
  logic       resync = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [1:0] mark_tag;
  logic       clk_err;
  logic       extra_err;
  logic       in_sync;

  always #2.5 clk = ~clk;

  amark_sync #(.PULSE_W(2)) i_amark_sync (
    .clk(clk), .rst_n(rst_n), .fm_mode(fm_mode), .win_valid(win_valid),
    .win_pulses(win_pulses), .win_is_data(win_is_data), .resync(resync),
    .byte_valid(byte_valid), .byte_data(byte_data), .mark_tag(mark_tag),
    .clk_err(clk_err), .extra_err(extra_err), .in_sync(in_sync));

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string req_q[$];
  bit prev_d = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_byte(input [7:0] d, input [1:0] t, input bit ce, input bit ee, input string req);
    exp_q.push_back({d, t, ce, ee});
    req_q.push_back(req);
  endtask

  // monitor: pops and compares every strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && byte_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R10 unexpected byte", {byte_data, mark_tag, clk_err, extra_err}, 0);
        else begin
          automatic logic [11:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          automatic logic [11:0] a = {byte_data, mark_tag, clk_err, extra_err};
          check(a == e, r, a, e);
        end
      end
    end
  end

  task automatic win(input [1:0] p, input bit d);
    @(negedge clk);
    win_valid = 1'b1; win_pulses = p; win_is_data = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    win_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic mfm_byte(input [7:0] b, input int bad_clk, input int xtra_bit);
    for (int i = 7; i >= 0; i--) begin
      automatic bit d = b[i];
      automatic bit c = !(prev_d | d);
      if (i == bad_clk) c = !c;
      win({1'b0, c}, 1'b0);
      win((i == xtra_bit && d) ? 2'd2 : {1'b0, d}, 1'b1);
      prev_d = d;
    end
  endtask

  task automatic fm_byte(input [7:0] b, input int bad_clk);
    for (int i = 7; i >= 0; i--) begin
      win((i == bad_clk) ? 2'd0 : 2'd1, 1'b0);
      win({1'b0, b[i]}, 1'b1);
    end
  endtask

  task automatic raw16(input [15:0] w);
    for (int i = 15; i >= 0; i--) win({1'b0, w[i]}, (i % 2) == 0);
    prev_d = w[0];
  endtask

  task automatic preamble();
    prev_d = 1'b0;
    if (fm_mode) begin fm_byte(8'h00, -1); fm_byte(8'h00, -1); end
    else begin mfm_byte(8'h00, -1, -1); mfm_byte(8'h00, -1, -1); end
  endtask

  task automatic do_resync(input bit fm);
    @(negedge clk);
    win_valid = 1'b0; resync = 1'b1; fm_mode = fm;
    @(negedge clk);
    resync = 1'b0;
    check(in_sync == 1'b0, "R11 in_sync after resync", in_sync, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_sync == 1'b0, "R12 in_sync in reset", in_sync, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_sync == 1'b0 && byte_valid == 1'b0, "R12 state after reset", {in_sync, byte_valid}, 0);

    // R10: traffic while hunting gives nothing
    mfm_byte(8'h5A, -1, -1);
    mfm_byte(8'h3C, -1, -1);
    mfm_byte(8'hA1, -1, -1);
    idle(3);
    check(in_sync == 1'b0, "R10 still hunting", in_sync, 0);

    // R1 first A1 prefix, R5 repeats
    preamble();
    expect_byte(8'hA1, 2'd1, 1'b0, 1'b0, "R1 first A1 prefix");
    raw16(16'h4489);
    expect_byte(8'hA1, 2'd2, 1'b0, 1'b0, "R5 repeated A1");
    raw16(16'h4489);
    expect_byte(8'hA1, 2'd2, 1'b0, 1'b0, "R5 repeated A1 third");
    raw16(16'h4489);
    idle(2);
    check(in_sync == 1'b1, "R1 in_sync after A1", in_sync, 1);

    // R4 normal bytes
    expect_byte(8'hFE, 2'd0, 1'b0, 1'b0, "R4 data FE");
    mfm_byte(8'hFE, -1, -1);
    expect_byte(8'h12, 2'd0, 1'b0, 1'b0, "R4 data 12");
    mfm_byte(8'h12, -1, -1);
    expect_byte(8'h80, 2'd0, 1'b0, 1'b0, "R4 data 80");
    mfm_byte(8'h80, -1, -1);
    // R6 missing clock between zeros
    expect_byte(8'h00, 2'd0, 1'b1, 1'b0, "R6 MFM clock violation");
    mfm_byte(8'h00, 4, -1);
    expect_byte(8'h55, 2'd0, 1'b0, 1'b0, "R6 clean byte after violation");
    mfm_byte(8'h55, -1, -1);
    // R9 extra pulse in a data window
    expect_byte(8'hF0, 2'd0, 1'b0, 1'b1, "R9 extra pulse");
    mfm_byte(8'hF0, -1, 7);
    expect_byte(8'h0F, 2'd0, 1'b0, 1'b0, "R9 flag cleared next byte");
    mfm_byte(8'h0F, -1, -1);
    idle(2);

    // R11 resync mid-byte: rest of byte yields nothing
    for (int i = 0; i < 5; i++) win(2'd1, (i % 2) == 1);
    do_resync(1'b0);
    mfm_byte(8'hE7, -1, -1);
    mfm_byte(8'h81, -1, -1);
    idle(2);
    check(in_sync == 1'b0, "R11 hunting after resync", in_sync, 0);

    // R2 C2 prefix and repeats
    preamble();
    expect_byte(8'hC2, 2'd1, 1'b0, 1'b0, "R2 first C2 prefix");
    raw16(16'h5224);
    expect_byte(8'hC2, 2'd2, 1'b0, 1'b0, "R5 repeated C2");
    raw16(16'h5224);
    expect_byte(8'h4E, 2'd0, 1'b0, 1'b0, "R4 data after C2");
    mfm_byte(8'h4E, -1, -1);
    idle(2);

    // R3 FM marks, R7 FM clock rule
    do_resync(1'b1);
    preamble();
    expect_byte(8'hFE, 2'd3, 1'b0, 1'b0, "R3 FM mark FE");
    raw16(16'hF57E);
    expect_byte(8'h9C, 2'd0, 1'b0, 1'b0, "R4 FM data 9C");
    fm_byte(8'h9C, -1);
    expect_byte(8'hFF, 2'd0, 1'b0, 1'b0, "R7 FM all ones clean");
    fm_byte(8'hFF, -1);
    expect_byte(8'hFF, 2'd0, 1'b1, 1'b0, "R7 FM missing clock");
    fm_byte(8'hFF, 2);
    expect_byte(8'h00, 2'd0, 1'b0, 1'b0, "R7 FM zeros clean");
    fm_byte(8'h00, -1);
    idle(2);

    begin
      automatic logic [15:0] pats[5] = '{16'hF56F, 16'hF56A, 16'hF56B, 16'hF56E, 16'hF77A};
      automatic logic [7:0]  vals[5] = '{8'hFB, 8'hF8, 8'hF9, 8'hFA, 8'hFC};
      for (int k = 0; k < 5; k++) begin
        do_resync(1'b1);
        preamble();
        expect_byte(vals[k], 2'd3, 1'b0, 1'b0, "R3 FM mark");
        raw16(pats[k]);
        idle(2);
        check(in_sync == 1'b1, "R3 in_sync after FM mark", in_sync, 1);
      end
    end

    idle(5);
    check(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule